// File: doc/BRIEF.md
# Ethernet Transmit Framer with Padding and Frame Check Sequence

This block sits in a byte-wide transmit path between a frame buffer and the line-side MAC logic. The buffer side offers frame bytes, from the destination address through the payload, on a valid/ready stream. Each beat carries a frame-start flag, a final-byte flag and an abort flag. The framer does four things to each frame. It puts the preamble and start delimiter in front. It can stretch short frames with zero bytes. It computes the CRC-32 frame check sequence and appends it. It closes an aborted frame with a deliberately corrupted check sequence.

Payload beats are passed through in the same cycle. The framer generates the preamble, pad and check bytes itself, and holds each one while the line side withholds ready. Two global settings are taken when a frame opens: automatic padding and check-sequence suppression. A per-frame check request is taken from the beat that carries the frame-start flag only. A frame must open with a beat that has the start flag set. Beats offered while idle without that flag are not consumed.

Top module: `eth_tx_framer`

## Requirements
- R1: A frame opens when a beat with `tx_first` is offered while idle. The framer then emits seven bytes of 0x55 and one byte of 0xD5, and only after these does it accept the first payload byte.
- R2: If `pad_enable` is 1 when the frame opens, payload shorter than 60 bytes is followed by 0x00 bytes until payload plus pad reaches 60 bytes. That is 544 bits with the preamble included. A payload of 60 bytes or more gets no pad.
- R3: A frame that received at least one pad byte always carries a check sequence, whatever `fcs_disable` and the per-frame request are.
- R4: With `fcs_disable` at 0, every frame that is not aborted ends with a four-byte check sequence.
- R5: With `fcs_disable` at 1 and no pad, a check sequence is appended only if `tx_add_fcs` was 1 on the frame-start beat. Its value on every later beat of the frame has no effect.
- R6: The check sequence is CRC-32 with the reflected polynomial 0xEDB88320. It is preset to all ones, covers payload and pad, and the register is sent complemented. The low byte goes out first, and each byte goes onto the line bit 0 first, so the x^31 term leads. The payload "123456789" gives the bytes 0x26, 0x39, 0xF4, 0xCB.
- R7: After reset the framer is idle: `line_valid`, `tx_ready` and `err_pulse` are 0.
- R8: A beat with `tx_abort` set, taken during the payload, is consumed without being forwarded. It raises `err_pulse` for exactly one cycle. The frame then ends with four bytes that are the bitwise inverse of the correct check sequence over the payload already sent. This happens regardless of the pad and check settings.
- R9: With padding off and no check sequence requested, payload bytes of any length, from 16 bytes up, leave unchanged. `line_eof` is on the last payload byte.
- R10: While `line_ready` is 0, a preamble, pad or check byte stays valid and unchanged. The pad count and the CRC advance only on accepted bytes.
- R11: `line_eof` is asserted on exactly the final byte of each frame. In the cycle after that byte is taken, `line_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_enable | input | 1 | Automatic padding on, sampled when a frame opens |
| fcs_disable | input | 1 | Suppress the check sequence unless requested or padded, sampled when a frame opens |
| tx_valid | input | 1 | Buffer-side beat valid |
| tx_data | input | 8 | Buffer-side byte |
| tx_first | input | 1 | Beat is the first of a frame |
| tx_last | input | 1 | Beat is the last payload byte |
| tx_abort | input | 1 | Beat reports an error; frame is aborted |
| tx_add_fcs | input | 1 | Per-frame check request, read on the first beat only |
| tx_ready | output | 1 | Buffer-side beat accepted |
| line_valid | output | 1 | Line-side byte valid |
| line_data | output | 8 | Line-side byte |
| line_eof | output | 1 | Line-side byte is the last of the frame |
| line_ready | input | 1 | Line side accepts the byte |
| err_pulse | output | 1 | One-cycle pulse when an abort is taken |

## Verification
The last payload byte has to resolve three things in a single cycle: whether to pad, whether to append a check sequence, and whether to raise `line_eof` on that same byte. The bench sets up frames of 59 and 60 bytes with padding on, and a short frame with check suppression on and no request. It also runs frames whose request differs between the first and later beats. In each case it compares the full line-side byte stream, including the position of the end marker, against a model built from the requirements. Abort collides with the running CRC in the same way. An abort beat is offered mid-frame under random back-pressure, and the inverted trailer is compared against an independently computed CRC of the bytes already sent.

// File: rtl/tx_framer_pkg.sv
// Shared definitions for the transmit framer: state encoding, fixed
// preamble byte values and a one-byte step of the reflected CRC-32.
package tx_framer_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_PAD,
        S_FCS
    } tx_state_e;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  DELIM_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY_REF  = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

    // Advance a reflected CRC-32 register by one byte, bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
        logic [31:0] c;
        c = crc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REF;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/tx_crc32.sv
// CRC-32 accumulator for the framer.
// Assumes: clear and upd are never asserted together with intent to update;
// clear wins. The register holds the uncomplemented running value.
module tx_crc32
    import tx_framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [7:0]  d,
    output logic [31:0] crc
);

    // Preset on reset or clear, advance by one byte on each update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_PRESET;
        else if (upd)        crc <= crc32_step(crc, d);
    end

endmodule

// File: rtl/tx_framer_ctl.sv
// Frame sequencer: emits preamble, forwards payload cut-through, inserts
// zero pad up to MIN_DATA bytes, then the check sequence (inverted on abort).
// Assumes: a frame opens with a tx_first beat; the buffer side holds a beat
// until tx_ready; abort never arrives on the frame-start beat.
module tx_framer_ctl
    import tx_framer_pkg::*;
#(
    parameter int PRE_BYTES = 8,
    parameter int MIN_DATA  = 60,
    parameter int FCS_BYTES = 4,
    parameter int CNT_W     = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_enable,
    input  logic              fcs_disable,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    input  logic              tx_first,
    input  logic              tx_last,
    input  logic              tx_abort,
    input  logic              tx_add_fcs,
    output logic              tx_ready,
    output logic              line_valid,
    output logic [7:0]        line_data,
    output logic              line_eof,
    input  logic              line_ready,
    output logic              err_pulse,
    input  logic [31:0]       crc_in,
    output logic              crc_clear,
    output logic              crc_upd,
    output logic [7:0]        crc_d
);

    localparam int PRE_W = $clog2(PRE_BYTES);
    localparam int FCS_W = $clog2(FCS_BYTES);
    localparam logic [CNT_W-1:0] MIN_C    = MIN_DATA[CNT_W-1:0];
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_BYTES - 1);
    localparam logic [FCS_W-1:0] FCS_LAST = FCS_W'(FCS_BYTES - 1);

    tx_state_e          st;
    logic [PRE_W-1:0]   pre_cnt;
    logic [CNT_W-1:0]   byte_cnt;
    logic [FCS_W-1:0]   fcs_idx;
    logic               pad_q, off_q, add_q, inv_q;

    logic               fire, abort_take, add_now, pad_need, fcs_need;
    logic [CNT_W-1:0]   cnt_next;
    logic [31:0]        fcs_src;

    // Handshake and end-of-payload decisions shared by both processes.
    always_comb begin
        fire       = line_valid && line_ready;
        abort_take = (st == S_DATA) && tx_valid && tx_abort;
        add_now    = tx_first ? tx_add_fcs : add_q;
        cnt_next   = byte_cnt + 1'b1;
        pad_need   = pad_q && (cnt_next < MIN_C);
        fcs_need   = pad_need || !off_q || add_now;
        fcs_src    = inv_q ? crc_in : ~crc_in;
    end

    // Output multiplexer and buffer-side ready per state.
    always_comb begin
        tx_ready   = 1'b0;
        line_valid = 1'b0;
        line_data  = 8'h00;
        line_eof   = 1'b0;
        err_pulse  = 1'b0;
        case (st)
            S_PRE: begin
                line_valid = 1'b1;
                line_data  = (pre_cnt == PRE_LAST) ? DELIM_BYTE : PREAMBLE_BYTE;
            end
            S_DATA: begin
                if (abort_take) begin
                    tx_ready  = 1'b1;
                    err_pulse = 1'b1;
                end else begin
                    tx_ready   = line_ready;
                    line_valid = tx_valid;
                    line_data  = tx_data;
                    line_eof   = tx_last && !fcs_need;
                end
            end
            S_PAD: begin
                line_valid = 1'b1;
            end
            S_FCS: begin
                line_valid = 1'b1;
                line_data  = fcs_src[8*fcs_idx +: 8];
                line_eof   = (fcs_idx == FCS_LAST);
            end
            default: ;
        endcase
        crc_clear = (st == S_IDLE);
        crc_upd   = fire && ((st == S_DATA) || (st == S_PAD));
        crc_d     = line_data;
    end

    // Frame sequencing, counters and frame-start sampling of settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            pre_cnt  <= '0;
            byte_cnt <= '0;
            fcs_idx  <= '0;
            pad_q    <= 1'b0;
            off_q    <= 1'b0;
            add_q    <= 1'b0;
            inv_q    <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (tx_valid && tx_first && !tx_abort) begin
                    st       <= S_PRE;
                    pre_cnt  <= '0;
                    byte_cnt <= '0;
                    fcs_idx  <= '0;
                    inv_q    <= 1'b0;
                    add_q    <= 1'b0;
                    pad_q    <= pad_enable;
                    off_q    <= fcs_disable;
                end
                S_PRE: if (fire) begin
                    pre_cnt <= pre_cnt + 1'b1;
                    if (pre_cnt == PRE_LAST) st <= S_DATA;
                end
                S_DATA: begin
                    if (abort_take) begin
                        inv_q <= 1'b1;
                        st    <= S_FCS;
                    end else if (fire) begin
                        byte_cnt <= cnt_next;
                        if (tx_first) add_q <= tx_add_fcs;
                        if (tx_last) begin
                            if (pad_need)      st <= S_PAD;
                            else if (fcs_need) st <= S_FCS;
                            else               st <= S_IDLE;
                        end
                    end
                end
                S_PAD: if (fire) begin
                    byte_cnt <= cnt_next;
                    if (cnt_next == MIN_C) st <= S_FCS;
                end
                S_FCS: if (fire) begin
                    fcs_idx <= fcs_idx + 1'b1;
                    if (fcs_idx == FCS_LAST) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1: no payload is taken while the preamble is still going out.
    p_pre_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRE) |-> !tx_ready);

    // R2: a padded, non-aborted frame reaches its trailer only at full length.
    p_pad_reaches_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FCS && pad_q && !inv_q) |-> (byte_cnt >= MIN_C));

    // R3: pad is never the final byte; it always leads on to the trailer.
    p_pad_then_fcs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAD && fire) |=> (st == S_PAD || st == S_FCS));

    // R8: an abort pulse is followed by the trailer with valid data.
    p_abort_trailer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (st == S_FCS && line_valid && !err_pulse));

    // R10: generated bytes stay put while the line side stalls.
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready && st != S_DATA) |=> (line_valid && $stable(line_data)));

    // R11: a gap follows the final byte of every frame.
    p_gap_after_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && line_eof) |=> !line_valid);

endmodule

// File: rtl/eth_tx_framer.sv
// Top of the transmit framer: sequencer plus CRC accumulator.
// Assumes: byte-wide streams on both sides, one clock domain, and a
// synchronous active-low reset.
module eth_tx_framer #(
    parameter int PRE_BYTES     = 8,
    parameter int MIN_BITS_FCS  = 544,
    parameter int FCS_BYTES     = 4,
    parameter int MAX_FRAME     = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_enable,
    input  logic       fcs_disable,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_first,
    input  logic       tx_last,
    input  logic       tx_abort,
    input  logic       tx_add_fcs,
    output logic       tx_ready,
    output logic       line_valid,
    output logic [7:0] line_data,
    output logic       line_eof,
    input  logic       line_ready,
    output logic       err_pulse
);

    localparam int MIN_DATA = MIN_BITS_FCS / 8 - PRE_BYTES;
    localparam int CNT_W    = $clog2(MAX_FRAME + 1);

    logic [31:0] crc;
    logic        crc_clear, crc_upd;
    logic [7:0]  crc_d;

    tx_framer_ctl #(
        .PRE_BYTES (PRE_BYTES),
        .MIN_DATA  (MIN_DATA),
        .FCS_BYTES (FCS_BYTES),
        .CNT_W     (CNT_W)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_enable  (pad_enable),
        .fcs_disable (fcs_disable),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_first    (tx_first),
        .tx_last     (tx_last),
        .tx_abort    (tx_abort),
        .tx_add_fcs  (tx_add_fcs),
        .tx_ready    (tx_ready),
        .line_valid  (line_valid),
        .line_data   (line_data),
        .line_eof    (line_eof),
        .line_ready  (line_ready),
        .err_pulse   (err_pulse),
        .crc_in      (crc),
        .crc_clear   (crc_clear),
        .crc_upd     (crc_upd),
        .crc_d       (crc_d)
    );

    tx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .upd   (crc_upd),
        .d     (crc_d),
        .crc   (crc)
    );

endmodule

// File: tb/tb_eth_tx_framer.sv
// Directed bench: one task per scenario, each comparing the full line-side
// stream with a model built from the requirements.
module tb_eth_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_enable = 1'b0, fcs_disable = 1'b0;
    logic       tx_valid = 1'b0, tx_first = 1'b0, tx_last = 1'b0;
    logic       tx_abort = 1'b0, tx_add_fcs = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, line_valid, line_eof, err_pulse;
    logic [7:0] line_data;
    logic       line_ready = 1'b1;

    int n_checks = 0, n_fail = 0, cycles = 0;
    logic [7:0] tx_buf [0:2047];
    logic [7:0] exp_d  [0:2199];
    logic [7:0] act_d  [0:2199];
    bit         act_eof[0:2199];
    int  n_act = 0, err_seen = 0, gap_bad = 0;
    bit  done = 0, gap_pending = 0, stall_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    eth_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .pad_enable(pad_enable), .fcs_disable(fcs_disable),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
        .tx_abort(tx_abort), .tx_add_fcs(tx_add_fcs), .tx_ready(tx_ready),
        .line_valid(line_valid), .line_data(line_data), .line_eof(line_eof),
        .line_ready(line_ready), .err_pulse(err_pulse)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Line-side back-pressure, pseudo-random when enabled.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        line_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Monitor sampling 1 ns before each rising edge.
    always begin
        @(negedge clk);
        #4;
        if (err_pulse) err_seen++;
        if (gap_pending) begin
            if (line_valid) gap_bad++;
            gap_pending = 0;
        end
        if (line_valid && line_ready && n_act < 2200) begin
            act_d[n_act]   = line_data;
            act_eof[n_act] = line_eof;
            n_act++;
            if (line_eof) begin done = 1; gap_pending = 1; end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(input int from, input int n);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = r[0] ^ exp_d[from + i][b];
                r  = {1'b0, r[31:1]};
                if (fb) r = r ^ 32'hEDB88320;
            end
        end
        return r;
    endfunction

    // Offer one buffer-side beat and wait until it is accepted.
    task automatic push(input logic [7:0] d, input bit f, input bit l,
                        input bit ab, input bit add);
        bit ok;
        tx_valid = 1'b1; tx_data = d; tx_first = f; tx_last = l;
        tx_abort = ab; tx_add_fcs = add;
        forever begin
            #4; ok = tx_ready;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    // Send a frame from tx_buf and compare the line stream with the model.
    task automatic run_frame(input string tag, input int len, input bit add_first,
                             input bit add_later, input int abort_at, input bit stall);
        int n_exp, data_n, body, first_bad;
        bit padded, want_fcs;
        logic [31:0] r;
        n_act = 0; err_seen = 0; gap_bad = 0; done = 0;
        stall_en = stall;
        @(negedge clk);
        data_n = (abort_at >= 0) ? abort_at : len;
        for (int i = 0; i < data_n; i++)
            push(tx_buf[i], i == 0, (i == len - 1) && (abort_at < 0), 1'b0,
                 (i == 0) ? add_first : add_later);
        if (abort_at >= 0) push(8'hEE, 1'b0, 1'b0, 1'b1, 1'b0);
        tx_valid = 1'b0; tx_first = 1'b0; tx_last = 1'b0; tx_abort = 1'b0; tx_add_fcs = 1'b0;
        for (int t = 0; t < 5000 && !done; t++) @(negedge clk);
        repeat (2) @(negedge clk);
        stall_en = 0;
        // Model: preamble, payload, pad, then trailer.
        for (int i = 0; i < 7; i++) exp_d[i] = 8'h55;
        exp_d[7] = 8'hD5;
        for (int i = 0; i < data_n; i++) exp_d[8 + i] = tx_buf[i];
        body = data_n;
        padded = 0;
        if (abort_at < 0 && pad_enable && len < 60) begin
            for (int i = len; i < 60; i++) exp_d[8 + i] = 8'h00;
            body = 60; padded = 1;
        end
        want_fcs = (abort_at >= 0) || padded || !fcs_disable || add_first;
        n_exp = 8 + body;
        if (want_fcs) begin
            r = model_crc(8, body);
            if (abort_at < 0) r = ~r;
            for (int k = 0; k < 4; k++) exp_d[n_exp + k] = r[8*k +: 8];
            n_exp += 4;
        end
        first_bad = -1;
        for (int i = 0; i < n_exp && i < n_act; i++)
            if (first_bad < 0 && (act_d[i] !== exp_d[i] || act_eof[i] != (i == n_exp - 1)))
                first_bad = i;
        chk(n_act == n_exp, tag, "byte count", n_act, n_exp);
        if (first_bad >= 0)
            chk(1'b0, tag, $sformatf("byte %0d (data/eof)", first_bad),
                {act_eof[first_bad], act_d[first_bad]},
                {(first_bad == n_exp - 1), exp_d[first_bad]});
        else
            chk(1'b1, tag, "stream", 0, 0);
        chk(err_seen == ((abort_at >= 0) ? 1 : 0), tag, "error pulses", err_seen,
            (abort_at >= 0) ? 1 : 0);
        chk(gap_bad == 0, "R11", "valid after eof", gap_bad, 0);
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) tx_buf[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
    endtask

    task automatic t_reset;
        #1;
        chk(line_valid == 1'b0, "R7", "line_valid in reset", line_valid, 0);
        chk(tx_ready == 1'b0 && err_pulse == 1'b0, "R7", "ready/err in reset",
            {tx_ready, err_pulse}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #4;
        chk(line_valid == 1'b0 && tx_ready == 1'b0, "R7", "idle after reset",
            {line_valid, tx_ready}, 0);
    endtask

    task automatic t_vector;   // R6, R4
        string s = "123456789";
        pad_enable = 0; fcs_disable = 0;
        for (int i = 0; i < 9; i++) tx_buf[i] = s[i];
        run_frame("R4", 9, 1'b0, 1'b0, -1, 1'b0);
        chk({act_d[n_act-4], act_d[n_act-3], act_d[n_act-2], act_d[n_act-1]} == 32'h2639F4CB,
            "R6", "known trailer", {act_d[n_act-4], act_d[n_act-3], act_d[n_act-2], act_d[n_act-1]},
            32'h2639F4CB);
        chk(act_d[7] == 8'hD5 && act_d[0] == 8'h55 && act_d[8] == 8'h31, "R1",
            "preamble/first payload", {act_d[0], act_d[7], act_d[8]}, 24'h55D531);
    endtask

    task automatic t_short_pad;   // R2, R3
        pad_enable = 1; fcs_disable = 1;
        fill(20, 1);
        run_frame("R3", 20, 1'b0, 1'b0, -1, 1'b0);
    endtask

    task automatic t_boundary;    // R2
        pad_enable = 1; fcs_disable = 0;
        fill(59, 2); run_frame("R2", 59, 1'b0, 1'b0, -1, 1'b0);
        fill(60, 3); run_frame("R2", 60, 1'b0, 1'b0, -1, 1'b0);
    endtask

    task automatic t_no_fcs;      // R9
        pad_enable = 0; fcs_disable = 1;
        fill(16, 4); run_frame("R9", 16, 1'b0, 1'b0, -1, 1'b0);
        fill(300, 5); run_frame("R9", 300, 1'b0, 1'b0, -1, 1'b1);
    endtask

    task automatic t_first_only;  // R5
        pad_enable = 0; fcs_disable = 1;
        fill(70, 6); run_frame("R5", 70, 1'b1, 1'b0, -1, 1'b0);
        fill(70, 7); run_frame("R5", 70, 1'b0, 1'b1, -1, 1'b0);
    endtask

    task automatic t_abort;       // R8
        pad_enable = 1; fcs_disable = 1;
        fill(30, 8); run_frame("R8", 30, 1'b0, 1'b0, 12, 1'b1);
    endtask

    task automatic t_stall;       // R10
        pad_enable = 1; fcs_disable = 0;
        fill(40, 9); run_frame("R10", 40, 1'b0, 1'b0, -1, 1'b1);
    endtask

    initial begin
        t_reset;
        t_vector;
        t_short_pad;
        t_boundary;
        t_no_fcs;
        t_first_only;
        t_abort;
        t_stall;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule